// File: doc/BRIEF.md
# Read Capture Delay Trainer

This block searches, one byte lane at a time, for a good read-capture delay setting on a DDR memory interface. For each lane it starts the delay tap at zero and repeatedly reads a fixed eight-byte reference pattern back from memory through a simple request/response read port. It first raises the tap until all eight bytes come back correctly. That tap is the start of the passing window. It then keeps raising the tap until a byte first fails. That tap is the end of the window. Finally it programs the tap halfway between the two.

Every single read is preceded by a pulse that flushes the PHY read FIFO and clears the sticky read-error flags, followed by an equally long settling gap. A read that returns with the masked or dummy error flag set counts as a miss, whatever its data. When a lane needs a tap increment while its tap is already at the top value, the lane is reported as failed.

A start pulse begins a run. When all lanes are finished, the block holds a done indication together with a per-lane pass vector and the final tap of every lane. These stay in place until the next start.

Top module: `dqs_trainer`

## Requirements
- R1: After reset, busy, done, every lane tap, every pass bit, the FIFO flush output and the read request are all 0.
- R2: A start pulse while idle or done begins a run that clears all taps and pass bits and trains lanes in ascending order from 0. Each lane's first read uses tap 0. A start pulse during a run has no effect.
- R3: Before every read, the FIFO flush and flag clear outputs are high together for exactly RST_CYC cycles. They are followed by exactly RST_CYC cycles with neither flush nor request before the request is raised.
- R4: Reading byte i (0..7) of lane L uses address L + 4*i. The request holds its valid and address stable until ready is seen.
- R5: Byte i is expected to be, in order, 0xFE, 0x11, 0x33, 0x55, 0x77, 0x99, 0xBB, 0xDD. A response counts as a hit only when its data matches and both the masked flag and the dummy flag are 0.
- R6: In the search for the window start, any miss raises the tap by one and restarts at byte 0. Eight consecutive hits record the current tap as the window start.
- R7: In the search for the window end, eight hits raise the tap by one and restart at byte 0. The first miss records the current tap as the window end.
- R8: If a tap increase is required while the tap is 31, the lane's pass bit stays 0, its tap stays 31, and training moves to the next lane.
- R9: After the window end is found, one extra flush pulse is issued. The lane's tap is then set to start + ((end - start) >> 1), and its pass bit is set to 1.
- R10: After the last lane, done goes high and busy low. Done, the pass vector and the taps stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a training run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; results valid |
| lane_ok | output | LANES | Per-lane pass bit |
| lane_tap | output | LANES*5 | Per-lane delay tap, lane L at bits [5L+4:5L] |
| fifo_rst | output | 1 | PHY read FIFO flush pulse |
| flag_clr | output | 1 | Clear of sticky read-error flags |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | $clog2(LANES+28) | Byte address of the read |
| rd_rsp_valid | input | 1 | Single-cycle read response strobe |
| rd_rsp_data | input | 8 | Returned byte |
| rd_rsp_masked | input | 1 | Read-data-masked error flag |
| rd_rsp_dummy | input | 1 | Read-data-dummy error flag |

## Verification
The bench builds the block with LANES=3 and RST_CYC=3. Three lanes bring in a lane count that is not a power of two and a third lane address offset. The short flush keeps full 32-tap sweeps brief, so windows that reach tap 31, windows of one tap, windows that start at tap 0, and lanes with no window at all can each be run to completion. The memory model stalls the request handshake at irregular points. It corrupts out-of-window reads per lane, either through bad data, the masked flag or the dummy flag, so every kind of miss is seen.

// File: rtl/dqs_train_pkg.sv
package dqs_train_pkg;

    localparam int TAP_W   = 5;
    localparam int PAT_LEN = 8;

    typedef logic [TAP_W-1:0] tap_t;
    localparam tap_t TAP_TOP = '1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LANE_INIT,
        ST_FLUSH,
        ST_SETTLE,
        ST_REQ,
        ST_WAIT,
        ST_TAIL_FLUSH,
        ST_NEXT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        V_NEXT_BYTE,
        V_RETRY,
        V_WIN_OPEN,
        V_FAIL,
        V_WIN_CLOSE
    } verdict_e;

    typedef struct packed {
        logic [7:0] data;
        logic       masked;
        logic       dummy;
    } rd_rsp_t;

    function automatic logic [7:0] ref_byte(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'hFE;
            3'd1:    return 8'h11;
            3'd2:    return 8'h33;
            3'd3:    return 8'h55;
            3'd4:    return 8'h77;
            3'd5:    return 8'h99;
            3'd6:    return 8'hBB;
            default: return 8'hDD;
        endcase
    endfunction

    function automatic tap_t window_mid(input tap_t lo, input tap_t hi);
        tap_t span;
        span = hi - lo;
        return lo + (span >> 1);
    endfunction

endpackage

// File: rtl/dqs_pulse_timer.sv
module dqs_pulse_timer #(
    parameter int CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CW'(CYC - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dqs_byte_check.sv
module dqs_byte_check
    import dqs_train_pkg::*;
(
    input  logic [2:0] idx,
    input  rd_rsp_t    rsp,
    output logic       hit
);
    always_comb begin
        hit = (rsp.data == ref_byte(idx)) && !rsp.masked && !rsp.dummy;
    end
endmodule

// File: rtl/dqs_lane_slot.sv
module dqs_lane_slot
    import dqs_train_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tap_we,
    input  tap_t tap_wdata,
    input  logic ok_set,
    output tap_t tap,
    output logic ok
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tap <= '0;
            ok  <= 1'b0;
        end else begin
            if (tap_we) tap <= tap_wdata;
            if (ok_set) ok  <= 1'b1;
        end
    end
endmodule

// File: rtl/dqs_trainer.sv
module dqs_trainer
    import dqs_train_pkg::*;
#(
    parameter int LANES   = 2,
    parameter int RST_CYC = 8,
    localparam int ADDR_W = $clog2(LANES + 28),
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    output logic                    busy,
    output logic                    done,
    output logic [LANES-1:0]        lane_ok,
    output logic [LANES*TAP_W-1:0]  lane_tap,
    output logic                    fifo_rst,
    output logic                    flag_clr,
    output logic                    rd_req_valid,
    input  logic                    rd_req_ready,
    output logic [ADDR_W-1:0]       rd_req_addr,
    input  logic                    rd_rsp_valid,
    input  logic [7:0]              rd_rsp_data,
    input  logic                    rd_rsp_masked,
    input  logic                    rd_rsp_dummy
);
    seq_state_e state_q;
    logic [LW-1:0] lane_q;
    logic [2:0]    idx_q;
    logic          phase_q;
    tap_t          win_start_q;

    tap_t     tap_arr [LANES];
    tap_t     cur_tap;
    tap_t     tap_wdata;
    logic     tap_we;
    logic     ok_we;
    logic     run_start;
    logic     timer_load;
    logic     timer_done;
    logic     hit;
    verdict_e verdict;
    rd_rsp_t  rsp;

    assign rsp       = '{data: rd_rsp_data, masked: rd_rsp_masked, dummy: rd_rsp_dummy};
    assign busy      = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign run_start = start && !busy;
    assign cur_tap   = tap_arr[lane_q];

    assign fifo_rst     = (state_q == ST_FLUSH) || (state_q == ST_TAIL_FLUSH);
    assign flag_clr     = fifo_rst;
    assign rd_req_valid = (state_q == ST_REQ);
    assign rd_req_addr  = ADDR_W'(32'(lane_q) + 32'(idx_q) * 4);

    dqs_byte_check u_cmp (
        .idx (idx_q),
        .rsp (rsp),
        .hit (hit)
    );

    dqs_pulse_timer #(.CYC(RST_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .expired (timer_done)
    );

    // Outcome of one compared byte
    always_comb begin
        logic last;
        last = (idx_q == 3'(PAT_LEN - 1));
        if (!phase_q) begin
            if (!hit)      verdict = (cur_tap == TAP_TOP) ? V_FAIL : V_RETRY;
            else if (last) verdict = V_WIN_OPEN;
            else           verdict = V_NEXT_BYTE;
        end else begin
            if (!hit)      verdict = V_WIN_CLOSE;
            else if (last) verdict = (cur_tap == TAP_TOP) ? V_FAIL : V_RETRY;
            else           verdict = V_NEXT_BYTE;
        end
    end

    always_comb begin
        timer_load = (state_q == ST_LANE_INIT)
                   || (state_q == ST_FLUSH && timer_done)
                   || (state_q == ST_WAIT && rd_rsp_valid && verdict != V_FAIL);
        tap_we    = 1'b0;
        tap_wdata = cur_tap;
        ok_we     = 1'b0;
        case (state_q)
            ST_LANE_INIT: begin
                tap_we    = 1'b1;
                tap_wdata = '0;
            end
            ST_WAIT: begin
                if (rd_rsp_valid && verdict == V_RETRY) begin
                    tap_we    = 1'b1;
                    tap_wdata = cur_tap + 1'b1;
                end
            end
            ST_TAIL_FLUSH: begin
                if (timer_done) begin
                    tap_we    = 1'b1;
                    tap_wdata = window_mid(win_start_q, cur_tap);
                    ok_we     = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            lane_q      <= '0;
            idx_q       <= '0;
            phase_q     <= 1'b0;
            win_start_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        lane_q  <= '0;
                        state_q <= ST_LANE_INIT;
                    end
                end
                ST_LANE_INIT: begin
                    idx_q   <= '0;
                    phase_q <= 1'b0;
                    state_q <= ST_FLUSH;
                end
                ST_FLUSH:  if (timer_done) state_q <= ST_SETTLE;
                ST_SETTLE: if (timer_done) state_q <= ST_REQ;
                ST_REQ:    if (rd_req_ready) state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rd_rsp_valid) begin
                        case (verdict)
                            V_NEXT_BYTE: begin
                                idx_q   <= idx_q + 1'b1;
                                state_q <= ST_FLUSH;
                            end
                            V_RETRY: begin
                                idx_q   <= '0;
                                state_q <= ST_FLUSH;
                            end
                            V_WIN_OPEN: begin
                                idx_q       <= '0;
                                phase_q     <= 1'b1;
                                win_start_q <= cur_tap;
                                state_q     <= ST_FLUSH;
                            end
                            V_FAIL:      state_q <= ST_NEXT;
                            default:     state_q <= ST_TAIL_FLUSH;
                        endcase
                    end
                end
                ST_TAIL_FLUSH: if (timer_done) state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (32'(lane_q) == LANES - 1) begin
                        state_q <= ST_DONE;
                    end else begin
                        lane_q  <= lane_q + 1'b1;
                        state_q <= ST_LANE_INIT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dqs_lane_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .clr       (run_start),
            .tap_we    (tap_we && (32'(lane_q) == g)),
            .tap_wdata (tap_wdata),
            .ok_set    (ok_we && (32'(lane_q) == g)),
            .tap       (tap_arr[g]),
            .ok        (lane_ok[g])
        );
        assign lane_tap[g*TAP_W +: TAP_W] = tap_arr[g];
    end
endmodule

// File: rtl/dqs_trainer_chk.sv
module dqs_trainer_chk #(
    parameter int LANES   = 2,
    parameter int RST_CYC = 8,
    parameter int ADDR_W  = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [LANES-1:0]     lane_ok,
    input logic [LANES*5-1:0]   lane_tap,
    input logic                 fifo_rst,
    input logic                 rd_req_valid,
    input logic                 rd_req_ready,
    input logic [ADDR_W-1:0]    rd_req_addr
);
    int flush_len_q;

    always_ff @(posedge clk) begin
        if (rst)           flush_len_q <= 0;
        else if (fifo_rst) flush_len_q <= flush_len_q + 1;
        else               flush_len_q <= 0;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && lane_ok == '0 && lane_tap == '0 && !fifo_rst && !rd_req_valid));

    assert_start_takes_R2: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy);

    assert_flush_short_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |-> flush_len_q < RST_CYC);

    assert_flush_full_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(fifo_rst) |-> (flush_len_q == RST_CYC && !rd_req_valid));

    assert_no_req_in_flush_R3: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |-> !rd_req_valid);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rd_req_valid && !fifo_rst));

    assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(lane_ok) && $stable(lane_tap));
endmodule

bind dqs_trainer dqs_trainer_chk #(
    .LANES   (LANES),
    .RST_CYC (RST_CYC),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .lane_ok      (lane_ok),
    .lane_tap     (lane_tap),
    .fifo_rst     (fifo_rst),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr)
);

// File: tb/test_dqs_trainer.sv
module test_dqs_trainer;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 3;
    localparam int RST_CYC    = 3;
    localparam int ADDR_W     = $clog2(LANES + 28);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic busy, done, fifo_rst, flag_clr, rd_req_valid;
    logic [LANES-1:0]   lane_ok;
    logic [LANES*5-1:0] lane_tap;
    logic [ADDR_W-1:0]  rd_req_addr;
    logic       rd_req_ready  = 1'b0;
    logic       rd_rsp_valid  = 1'b0;
    logic [7:0] rd_rsp_data   = 8'h00;
    logic       rd_rsp_masked = 1'b0;
    logic       rd_rsp_dummy  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqs_trainer #(.LANES(LANES), .RST_CYC(RST_CYC)) i_dqs_trainer (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .lane_ok(lane_ok), .lane_tap(lane_tap), .fifo_rst(fifo_rst),
        .flag_clr(flag_clr), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .rd_rsp_masked(rd_rsp_masked), .rd_rsp_dummy(rd_rsp_dummy)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        logic [7:0] p [8] = '{8'hFE, 8'h11, 8'h33, 8'h55, 8'h77, 8'h99, 8'hBB, 8'hDD};
        return p[i];
    endfunction

    // Per-lane window model: mode 0 bad data, 1 masked flag, 2 dummy flag
    int win_lo [LANES];
    int win_hi [LANES];
    int win_md [LANES];

    typedef struct { int lane; bit ok; int tap; } exp_t;
    exp_t exp_q [$];

    // Memory model and protocol monitors
    bit pend = 0;
    int lat_addr, lat_tap, stall = 0, seed = 0;
    int reads = 0, pulses = 0, gap = 0, plen = 0;
    int gap_err = 0, clr_err = 0, order_err = 0, seq_err = 0;
    int seen_lane = -1, exp_byte = 0;
    logic prev_fifo = 1'b0, prev_valid = 1'b0;

    always @(negedge clk) begin
        rd_rsp_valid  = 1'b0;
        rd_rsp_masked = 1'b0;
        rd_rsp_dummy  = 1'b0;
        if (rst) begin
            rd_req_ready = 1'b0;
            pend = 0;
        end else begin
            if (flag_clr !== fifo_rst) clr_err++;
            if (fifo_rst && !prev_fifo) begin pulses++; plen = 0; end
            if (fifo_rst) plen++;
            if (!fifo_rst && prev_fifo) begin
                if (plen != RST_CYC) gap_err++;
                gap = 0;
            end
            if (!fifo_rst && !rd_req_valid) gap++;
            if (rd_req_valid && !prev_valid && gap != RST_CYC) gap_err++;

            if (pend) begin
                int ln, by;
                bit good;
                ln = lat_addr % 4;
                by = lat_addr / 4;
                good = (lat_tap >= win_lo[ln]) && (lat_tap <= win_hi[ln]);
                rd_req_ready = 1'b0;
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = pat(by);
                if (!good) begin
                    if (win_md[ln] == 0)      rd_rsp_data = pat(by) ^ 8'h24;
                    else if (win_md[ln] == 1) rd_rsp_masked = 1'b1;
                    else                      rd_rsp_dummy = 1'b1;
                end
                exp_byte = (good && by < 7) ? by + 1 : 0;
                reads++;
                pend = 0;
            end else if (rd_req_valid) begin
                if (stall > 0) begin
                    stall--;
                    rd_req_ready = 1'b0;
                end else begin
                    int ln;
                    rd_req_ready = 1'b1;
                    pend = 1;
                    lat_addr = int'(rd_req_addr);
                    ln = lat_addr % 4;
                    lat_tap = int'(lane_tap[ln*5 +: 5]);
                    if (ln != seen_lane) begin
                        if (ln != seen_lane + 1 || lat_tap != 0) order_err++;
                        seen_lane = ln;
                        exp_byte = 0;
                    end
                    if (lat_addr / 4 != exp_byte) seq_err++;
                    seed++;
                    stall = (seed % 5 == 2) ? 2 : 0;
                end
            end
        end
        prev_fifo  = fifo_rst;
        prev_valid = rd_req_valid;
    end

    // Scoreboard monitor: pops expected lane results when done rises
    logic prev_done = 1'b0;
    int done_rises = 0;
    always @(negedge clk) begin
        if (!rst && done && !prev_done) begin
            done_rises++;
            for (int l = 0; l < LANES; l++) begin
                exp_t e;
                int t;
                if (exp_q.size() == 0) begin
                    chk(0, "R10 result without expectation", l, 0);
                end else begin
                    e = exp_q.pop_front();
                    t = int'(lane_tap[e.lane*5 +: 5]);
                    chk(lane_ok[e.lane] == e.ok, e.ok ? "R9 lane pass bit" : "R8 lane pass bit",
                        int'(lane_ok[e.lane]), int'(e.ok));
                    chk(t == e.tap, e.ok ? "R9 centred tap" : "R8 tap left at 31", t, e.tap);
                end
            end
        end
        prev_done = done;
    end

    // Driver: computes expectations, pushes them, runs one training pass
    task automatic run_case(input int lo0, input int hi0, input int m0,
                            input int lo1, input int hi1, input int m1,
                            input int lo2, input int hi2, input int m2,
                            input bit poke_start);
        int oks;
        win_lo = '{lo0, lo1, lo2};
        win_hi = '{hi0, hi1, hi2};
        win_md = '{m0, m1, m2};
        oks = 0;
        for (int l = 0; l < LANES; l++) begin
            exp_t e;
            e.lane = l;
            if (win_lo[l] > 31 || win_hi[l] >= 31) begin
                e.ok = 0; e.tap = 31;
            end else begin
                e.ok = 1; e.tap = win_lo[l] + ((win_hi[l] + 1 - win_lo[l]) >> 1);
                oks++;
            end
            exp_q.push_back(e);
        end
        reads = 0; pulses = 0; gap_err = 0; clr_err = 0;
        order_err = 0; seq_err = 0; seen_lane = -1; done_rises = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(lane_ok == '0, "R2 pass bits cleared", int'(lane_ok), 0);
        if (poke_start) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R10 done held, busy low", int'(done), 1);
        chk(done_rises == 1, "R2 single completion per run", done_rises, 1);
        chk(pulses == reads + oks, "R9 extra flush per passing lane", pulses, reads + oks);
        chk(gap_err == 0, "R3 flush and settle lengths", gap_err, 0);
        chk(clr_err == 0, "R3 flag clear with flush", clr_err, 0);
        chk(order_err == 0, "R2 lane order and tap 0 start", order_err, 0);
        chk(seq_err == 0, "R4 byte address sequence", seq_err, 0);
        chk(exp_q.size() == 0, "R10 all lanes reported", exp_q.size(), 0);
    endtask

    initial begin
        win_lo = '{0, 0, 0};
        win_hi = '{0, 0, 0};
        win_md = '{0, 0, 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R1 busy/done after reset", int'(busy) + int'(done), 0);
        chk(lane_tap == '0 && lane_ok == '0, "R1 taps and pass bits after reset", int'(lane_tap), 0);
        chk(fifo_rst == 0 && rd_req_valid == 0, "R1 flush/request idle", int'(fifo_rst), 0);

        // R5 R6 R7: data, masked and dummy misses; last lane window reaches 31
        run_case(5, 12, 0,   0, 7, 1,   20, 31, 2, 1'b1);
        // R8: window only at 31, no window at all; one-tap window
        run_case(31, 31, 1,  40, 40, 0,  10, 10, 2, 1'b0);
        // R9: wide window from 0, narrow window, window ending at 30
        run_case(0, 30, 2,   3, 4, 0,    30, 30, 1, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule